// File: doc/BRIEF.md
# Presettable Synchronous Cascadable Binary Counter

This block is one stage of a synchronous binary up-counter, 4 bits wide by default. Every change to its state happens on the rising clock edge. That includes clearing to zero, loading a preset word and counting up by one. The three actions follow a fixed order of priority: clear first, then load, then count. Both the clear and the load are active low.

Two active-high enables gate the counting. The parallel enable is shared by every stage of a chain. The trickle enable also drives the stage's terminal-count output, and that path is purely combinational. The output rises when the trickle enable is high and the count is all ones. It is meant to feed the trickle enable of the next stage, so a row of stages works as one wide counter with look-ahead carry.

A decoder on the count can be wired back into the synchronous clear. This shortens the counting cycle to any modulus that is needed.

Top module: `sync_bin_counter`

## Requirements
- R1: With `clr_n` low at a rising edge, `q` becomes all zeros after that edge, whatever the levels on `load_n`, `en_p` and `en_t`.
- R2: With `clr_n` high and `load_n` low at a rising edge, `q` takes the value of `din` after that edge, whatever the levels on both enables.
- R3: With `clr_n`, `load_n`, `en_p` and `en_t` all high at a rising edge, `q` increments by one modulo 2^W, so all ones wraps to all zeros.
- R4: With `clr_n` and `load_n` high and either enable low, `q` keeps its value across the edge.
- R5: `tc` is 1 exactly when `en_t` is 1 and `q` is all ones. It responds to `en_t` without a clock edge, and `en_p` has no effect on it.
- R6: `q` changes only at a rising clock edge. Input changes between edges leave `q` unchanged until the next edge.
- R7: Three stages form one 12-bit counter when each later stage takes `en_t` from the previous stage's `tc` and all stages share `en_p`. The lowest stage is bits 3:0.
- R8: With `load_n` tied high, both enables tied high, and `clr_n` driven low whenever `q` equals 9, a stage counts 0 through 9 and then returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_p | input | 1 | Parallel count enable, active high |
| en_t | input | 1 | Trickle count enable, active high; also gates `tc` |
| din | input | W | Preset word taken on a load |
| q | output | W | Registered count |
| tc | output | 1 | Terminal count: `en_t` AND count all ones |

## Verification
The hardest case to reach is a carry that ripples through every stage of a chain at once. That happens only at the edge where the whole 12-bit value goes from all ones to zero. Reaching it by plain counting would take thousands of cycles. The stimulus instead uses the load to preset the chain to just below the stage boundaries, for example 0x7FE, 0x0F0 and 0xFFD, and then counts across them. A reference integer in the scoreboard gives the expected value at each edge. Mid-cycle samples confirm that the combinational terminal count follows `en_t` while `en_p` is low.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD  = 2'd0,
    CNT_INC   = 2'd1,
    CNT_LOAD  = 2'd2,
    CNT_CLEAR = 2'd3
  } cnt_op_t;
endpackage

// File: rtl/cnt_ctrl.sv
// Resolves the control pins into a single operation, clear > load > count.
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic    clr_n,
  input  logic    load_n,
  input  logic    en_p,
  input  logic    en_t,
  output cnt_op_t op
);
  always_comb begin
    if (!clr_n)             op = CNT_CLEAR;
    else if (!load_n)       op = CNT_LOAD;
    else if (en_p && en_t)  op = CNT_INC;
    else                    op = CNT_HOLD;
  end
endmodule

// File: rtl/cnt_reg.sv
// Count register with a per-bit look-ahead toggle chain.
module cnt_reg
  import cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  cnt_op_t      op,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] carry;
  logic [W-1:0] inc;

  assign carry[0] = 1'b1;
  generate
    for (genvar i = 1; i < W; i++) begin : g_carry
      assign carry[i] = carry[i-1] & q[i-1];
    end
    for (genvar i = 0; i < W; i++) begin : g_inc
      assign inc[i] = q[i] ^ carry[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    case (op)
      CNT_CLEAR: q <= '0;
      CNT_LOAD:  q <= din;
      CNT_INC:   q <= inc;
      default:   q <= q;
    endcase
  end
endmodule

// File: rtl/cnt_carry.sv
// Combinational terminal count gated by the trickle enable.
module cnt_carry #(
  parameter int W = 4
) (
  input  logic [W-1:0] q,
  input  logic         en_t,
  output logic         tc
);
  assign tc = en_t & (&q);
endmodule

// File: rtl/sync_bin_counter.sv
module sync_bin_counter
  import cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         en_p,
  input  logic         en_t,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         tc
);
  cnt_op_t op;

  cnt_ctrl u_ctrl (
    .clr_n  (clr_n),
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .op     (op)
  );

  cnt_reg #(.W(W)) u_reg (
    .clk (clk),
    .op  (op),
    .din (din),
    .q   (q)
  );

  cnt_carry #(.W(W)) u_carry (
    .q    (q),
    .en_t (en_t),
    .tc   (tc)
  );
endmodule

// File: rtl/cnt_checker.sv
module cnt_checker #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         clr_n,
  input logic         load_n,
  input logic         en_p,
  input logic         en_t,
  input logic [W-1:0] din,
  input logic [W-1:0] q,
  input logic         tc
);
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ONES = '1;

  // Count is only defined once a clear edge has been seen.
  logic primed = 1'b0;
  always_ff @(posedge clk) if (!clr_n) primed <= 1'b1;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!primed)
    !clr_n |=> (q == '0)); // R1
  AST_LOAD_TAKES_DIN: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && !load_n) |=> (q == $past(din))); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && load_n && en_p && en_t) |=> (q == $past(q) + ONE)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && load_n && !(en_p && en_t)) |=> $stable(q)); // R4
  AST_TC_ON_FULL: assert property (@(posedge clk) disable iff (!primed)
    (en_t && (q == ONES)) |-> tc); // R5
  AST_TC_NEEDS_TRICKLE: assert property (@(posedge clk) disable iff (!primed)
    tc |-> (en_t && (q == ONES))); // R5
endmodule

bind sync_bin_counter cnt_checker #(.W(W)) u_chk (.*);

// File: tb/tb_sync_bin_counter.sv
module tb_sync_bin_counter;
  logic        clk = 1'b0;
  logic        clr_n = 1'b1, load_n = 1'b1, en_p = 1'b0, en_t0 = 1'b0;
  logic [11:0] din = '0;
  logic [3:0]  q0, q1, q2, mq;
  logic        tc0, tc1, tc2, mtc;
  logic [11:0] q12;
  logic        mclr_n;

  int checks = 0;
  int errors = 0;
  logic [11:0] ref12 = '0;
  logic [3:0]  refm = '0;

  typedef struct {
    logic [11:0] cnt;
    logic [3:0]  m;
    string       tag;
  } item_t;
  item_t sbq[$];

  always #10 clk = ~clk;

  // R7 chain: lowest stage bits 3:0, trickle enable from previous tc
  sync_bin_counter #(.W(4)) dut (.clk(clk), .clr_n(clr_n), .load_n(load_n),
    .en_p(en_p), .en_t(en_t0), .din(din[3:0]), .q(q0), .tc(tc0));
  sync_bin_counter #(.W(4)) stg1 (.clk(clk), .clr_n(clr_n), .load_n(load_n),
    .en_p(en_p), .en_t(tc0), .din(din[7:4]), .q(q1), .tc(tc1));
  sync_bin_counter #(.W(4)) stg2 (.clk(clk), .clr_n(clr_n), .load_n(load_n),
    .en_p(en_p), .en_t(tc1), .din(din[11:8]), .q(q2), .tc(tc2));
  assign q12 = {q2, q1, q0};

  // R8 decade counter: decoded 9 drives the synchronous clear
  assign mclr_n = clr_n & ~(mq == 4'd9);
  sync_bin_counter #(.W(4)) modc (.clk(clk), .clr_n(mclr_n), .load_n(1'b1),
    .en_p(1'b1), .en_t(1'b1), .din(4'd0), .q(mq), .tc(mtc));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: compares after each edge, away from the edge
  initial forever begin
    @(negedge clk);
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      chk(q12 == it.cnt, it.tag, int'(q12), int'(it.cnt));
      chk(mq == it.m, "R8 truncated modulus", int'(mq), int'(it.m));
    end
  end

  // Driver: applies one cycle of stimulus and queues the expected result
  task automatic step(input logic c, input logic l, input logic p,
                      input logic t, input logic [11:0] d);
    item_t it;
    @(negedge clk);
    clr_n = c; load_n = l; en_p = p; en_t0 = t; din = d;
    #2;
    chk(q12 == ref12, "R6 no change before edge", int'(q12), int'(ref12));
    chk(tc2 == (t && ref12 == 12'hFFF), "R5 combinational tc", int'(tc2),
        int'(t && ref12 == 12'hFFF));
    if (!c)            begin ref12 = '0;        it.tag = "R1 clear priority"; end
    else if (!l)       begin ref12 = d;         it.tag = "R2 load priority"; end
    else if (p && t)   begin ref12 = ref12 + 12'd1; it.tag = "R3/R7 chain increment"; end
    else               it.tag = "R4 hold";
    refm = (!c || refm == 4'd9) ? 4'd0 : refm + 4'd1;
    it.cnt = ref12;
    it.m   = refm;
    @(posedge clk);
    sbq.push_back(it);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(0, 1, 1, 1, 12'h000);            // R1 reset state
    step(0, 0, 1, 1, 12'hABC);            // R1 clear beats load
    step(1, 0, 0, 0, 12'h123);            // R2 load with enables low
    step(1, 0, 1, 1, 12'h7FE);            // R2 load beats count
    for (int i = 0; i < 5; i++) step(1, 1, 1, 1, 12'h0);  // R3 R7 cross 7FF
    step(1, 1, 0, 1, 12'h0);              // R4 en_p low
    step(1, 1, 1, 0, 12'h0);              // R4 en_t low
    step(1, 0, 0, 0, 12'hFFD);
    for (int i = 0; i < 5; i++) step(1, 1, 1, 1, 12'h0);  // R3 wrap FFF->000
    step(1, 0, 1, 1, 12'hFFF);
    step(1, 1, 0, 1, 12'h0);              // R5 tc high while en_p low
    step(1, 1, 0, 0, 12'h0);              // R5 tc low with en_t low
    step(1, 1, 1, 0, 12'h0);
    step(1, 0, 1, 1, 12'h0F0);
    for (int i = 0; i < 40; i++) step(1, 1, 1, 1, 12'h0); // R7 cross 0FF
    step(0, 1, 1, 1, 12'h0);
    for (int i = 0; i < 30; i++) step(1, 1, 1, 1, 12'h0); // R8 decade wraps
    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule